// File: doc/BRIEF.md
# Stop-Mode Standby Controller

The controller moves a small microcontroller-style system into and out of a low-power stop state. A software stop request gates the main system clock and takes the CPU out of run. Only the main clock stops: the subsystem clock runs on whenever it is present. While the system is stopped, the controller holds the port output latches and releases the external expansion bus, so its outputs go to high impedance. It also keeps the watchdog counter in its initial state. Each peripheral gets its own enable, which depends on where that peripheral takes its count clock from.

While stopped, the controller watches a fixed set of wake sources: the non-maskable interrupt, six external interrupt inputs and the watch-timer interrupt. When one of them is asserted, the controller waits a programmable number of reference-clock cycles so that the oscillator can settle. It then re-enables the main clock and returns to run. Any other interrupt request that arrives while the system is out of run is kept pending and is forwarded in the first run cycle.

The controller runs on an always-on reference clock. Its state is visible on a two-bit status output.

Top module: `stop_ctrl`

## Requirements
- R1: After reset the status is run (code 00), the main clock enable, CPU run, bus output enable and every peripheral enable are 1, and watchdog clear is 0.
- R2: In run, a stop request with no wake source asserted gives stopping (01) after one clock and stopped (10) after the next. Main clock enable and CPU run are 0 in every state except run.
- R3: The subsystem clock enable equals the subsystem-present input in every state.
- R4: In run, the port output follows the port input one clock later. Outside run it keeps the value it had on the last run clock edge.
- R5: Outside run, the bus output enable is 0 (high impedance) and watchdog clear is 1.
- R6: Outside run, each 8-bit timer enable equals its external-pin select bit. The 16-bit timer enable and the watch timer enable are each their subsystem-clock select ANDed with subsystem-present.
- R7: Outside run, each serial enable is its external-clock select AND NOT its I2C-mode bit. The A/D enable is 0, and the D/A enable and external-interrupt enable are 1.
- R8: Only the non-maskable interrupt, any of the six external interrupts or the watch-timer interrupt move stopped to waking (11). The other interrupt inputs leave the state unchanged.
- R9: Other interrupt requests seen outside run are stored. The forwarded interrupt output is 0 outside run and shows the stored requests in the first run cycle, after which they clear.
- R10: Waking lasts exactly stab_cycles+1 clocks, then the status returns to run.
- R11: A stop request made while any wake source is asserted is ignored, and the state stays run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Software stop request |
| sub_present | input | 1 | Subsystem clock is configured and running |
| stab_cycles | input | CW | Oscillator settling clocks after a wake |
| tmr8_pin_sel | input | N8 | Per 8-bit timer: count clock taken from its external pin |
| t16_sub_sel | input | 1 | 16-bit timer counts from the subsystem clock |
| wt_sub_sel | input | 1 | Watch timer counts from the subsystem clock |
| ser_ext_clk | input | NSER | Per serial channel: external serial clock selected |
| ser_i2c | input | NSER | Per serial channel: I2C mode |
| nmi | input | 1 | Non-maskable interrupt |
| ext_irq | input | NEXT | External interrupt inputs |
| wt_irq | input | 1 | Watch-timer interrupt |
| other_irq | input | NOTH | Interrupt requests that cannot wake |
| port_d | input | PW | Port output latch data from the CPU side |
| port_q | output | PW | Port output latch value at the pins |
| irq_out | output | NOTH | Forwarded interrupt requests |
| main_clk_en | output | 1 | Main system clock gate enable |
| sub_clk_en | output | 1 | Subsystem clock gate enable |
| cpu_run | output | 1 | CPU may execute |
| bus_oe | output | 1 | External bus output enable (0 = high impedance) |
| wdt_clr | output | 1 | Hold watchdog counter at its initial value |
| tmr8_en | output | N8 | 8-bit timer enables |
| t16_en | output | 1 | 16-bit timer enable |
| wt_en | output | 1 | Watch timer enable |
| ser_en | output | NSER | Serial channel enables |
| adc_en | output | 1 | A/D converter enable |
| dac_en | output | 1 | D/A converter enable |
| extint_en | output | 1 | External interrupt logic enable |
| status | output | 2 | 00 run, 01 stopping, 10 stopped, 11 waking |

## Verification
The peripheral-enable logic is swept with the system stopped. The sweep covers all 128 combinations of timer pin selects, subsystem presence and the two subsystem-clock selects, and all 16 serial external-clock and I2C combinations. This separates a missing AND with subsystem-present from a wrong per-bit mapping. Each wake source is tried on its own against each non-waking interrupt bit, to show that only the fixed subset ends stop. The settling count is swept from 0 to 5, which exposes off-by-one errors in the waking length. Port data is changed during stop, which separates a true hold from a latch that keeps following its input.

// File: rtl/stop_ctrl.sv
module stop_ctrl #(
  parameter int N8   = 4,
  parameter int NSER = 2,
  parameter int NEXT = 6,
  parameter int NOTH = 4,
  parameter int PW   = 8,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_req,
  input  logic            sub_present,
  input  logic [CW-1:0]   stab_cycles,
  input  logic [N8-1:0]   tmr8_pin_sel,
  input  logic            t16_sub_sel,
  input  logic            wt_sub_sel,
  input  logic [NSER-1:0] ser_ext_clk,
  input  logic [NSER-1:0] ser_i2c,
  input  logic            nmi,
  input  logic [NEXT-1:0] ext_irq,
  input  logic            wt_irq,
  input  logic [NOTH-1:0] other_irq,
  input  logic [PW-1:0]   port_d,
  output logic [PW-1:0]   port_q,
  output logic [NOTH-1:0] irq_out,
  output logic            main_clk_en,
  output logic            sub_clk_en,
  output logic            cpu_run,
  output logic            bus_oe,
  output logic            wdt_clr,
  output logic [N8-1:0]   tmr8_en,
  output logic            t16_en,
  output logic            wt_en,
  output logic [NSER-1:0] ser_en,
  output logic            adc_en,
  output logic            dac_en,
  output logic            extint_en,
  output logic [1:0]      status
);

  typedef enum logic [1:0] {S_RUN = 2'b00, S_STOPPING = 2'b01, S_STOPPED = 2'b10, S_WAKING = 2'b11} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [NOTH-1:0] pend;
  logic            wake_any;
  logic            run;

  assign wake_any = nmi | (|ext_irq) | wt_irq;
  assign run      = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN:
          if (stop_req && !wake_any) st <= S_STOPPING;
        S_STOPPING:
          if (wake_any) begin
            st  <= S_WAKING;
            cnt <= stab_cycles;
          end else begin
            st <= S_STOPPED;
          end
        S_STOPPED:
          if (wake_any) begin
            st  <= S_WAKING;
            cnt <= stab_cycles;
          end
        S_WAKING:
          if (cnt == '0) st <= S_RUN;
          else           cnt <= cnt - 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      pend   <= '0;
    end else begin
      if (run) port_q <= port_d;
      pend <= run ? '0 : (pend | other_irq);
    end
  end

  assign irq_out     = run ? (other_irq | pend) : '0;
  assign status      = st;
  assign main_clk_en = run;
  assign cpu_run     = run;
  assign sub_clk_en  = sub_present;
  assign bus_oe      = run;
  assign wdt_clr     = !run;
  assign tmr8_en     = run ? '1 : tmr8_pin_sel;
  assign t16_en      = run | (t16_sub_sel & sub_present);
  assign wt_en       = run | (wt_sub_sel & sub_present);
  assign ser_en      = run ? '1 : (ser_ext_clk & ~ser_i2c);
  assign adc_en      = run;
  assign dac_en      = 1'b1;
  assign extint_en   = 1'b1;

  p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && stop_req && !wake_any) |=> (status == 2'b01));

  p_stopping_leaves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOPPING) |=> (status != 2'b00 && !main_clk_en));

  p_port_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |=> $stable(port_q));

  p_no_wake_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOPPED && !wake_any) |=> (status == 2'b10));

  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOPPED && wake_any) |=> (status == 2'b11));

  p_ignore_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && wake_any) |=> (status == 2'b00));

  p_pend_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN && other_irq[0]) |=> (status == 2'b00 ? irq_out[0] : pend[0]));

endmodule

// File: tb/stop_ctrl_bench.sv
module stop_ctrl_bench;
  localparam int N8 = 4, NSER = 2, NEXT = 6, NOTH = 4, PW = 8, CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, sub_present = 0, t16_sub_sel = 0, wt_sub_sel = 0, nmi = 0, wt_irq = 0;
  logic [CW-1:0] stab_cycles = '0;
  logic [N8-1:0] tmr8_pin_sel = '0;
  logic [NSER-1:0] ser_ext_clk = '0, ser_i2c = '0;
  logic [NEXT-1:0] ext_irq = '0;
  logic [NOTH-1:0] other_irq = '0;
  logic [PW-1:0] port_d = '0;
  logic [PW-1:0] port_q;
  logic [NOTH-1:0] irq_out;
  logic main_clk_en, sub_clk_en, cpu_run, bus_oe, wdt_clr, t16_en, wt_en, adc_en, dac_en, extint_en;
  logic [N8-1:0] tmr8_en;
  logic [NSER-1:0] ser_en;
  logic [1:0] status;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stop_ctrl #(.N8(N8), .NSER(NSER), .NEXT(NEXT), .NOTH(NOTH), .PW(PW), .CW(CW)) u_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .sub_present(sub_present),
    .stab_cycles(stab_cycles), .tmr8_pin_sel(tmr8_pin_sel), .t16_sub_sel(t16_sub_sel),
    .wt_sub_sel(wt_sub_sel), .ser_ext_clk(ser_ext_clk), .ser_i2c(ser_i2c), .nmi(nmi),
    .ext_irq(ext_irq), .wt_irq(wt_irq), .other_irq(other_irq), .port_d(port_d),
    .port_q(port_q), .irq_out(irq_out), .main_clk_en(main_clk_en), .sub_clk_en(sub_clk_en),
    .cpu_run(cpu_run), .bus_oe(bus_oe), .wdt_clr(wdt_clr), .tmr8_en(tmr8_en),
    .t16_en(t16_en), .wt_en(wt_en), .ser_en(ser_en), .adc_en(adc_en), .dac_en(dac_en),
    .extint_en(extint_en), .status(status));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic go_stop();
    stop_req = 1; step(); stop_req = 0;
    chk("R2 stopping", {30'd0, status}, 32'd1);
    chk("R2 clk gated", {30'd0, main_clk_en, cpu_run}, 32'd0);
    step();
    chk("R2 stopped", {30'd0, status}, 32'd2);
  endtask

  task automatic wake_and_count(input int stab, output int n);
    n = 0;
    while (status == 2'b11 && n < 300) begin
      chk("R2 waking gated", {31'd0, main_clk_en}, 32'd0);
      n++;
      step();
    end
    chk("R10 waking length", n, stab + 1);
    chk("R10 back to run", {30'd0, status}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    step(); step();
    chk("R1 status", {30'd0, status}, 32'd0);
    chk("R1 enables", {18'd0, main_clk_en, cpu_run, bus_oe, wdt_clr, tmr8_en, t16_en, wt_en, ser_en, adc_en, dac_en, extint_en},
        {18'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1});
    rst_n = 1;
    step();

    // R4: port follows in run
    port_d = 8'hA5; step();
    chk("R4 follow", {24'd0, port_q}, 32'hA5);

    // R11: stop ignored while wake asserted
    for (int k = 0; k < 3; k++) begin
      nmi = (k == 0); ext_irq = (k == 1) ? 6'h20 : 6'h0; wt_irq = (k == 2);
      stop_req = 1; step(); stop_req = 0;
      chk("R11 ignored", {30'd0, status}, 32'd0);
      step();
      chk("R11 still run", {30'd0, status}, 32'd0);
    end
    nmi = 0; ext_irq = 0; wt_irq = 0;

    // Enter stop, check R5, R4 hold, R3
    stab_cycles = 8'd2;
    go_stop();
    chk("R5 bus hiz", {31'd0, bus_oe}, 32'd0);
    chk("R5 wdt clear", {31'd0, wdt_clr}, 32'd1);
    port_d = 8'h3C; step();
    chk("R4 hold", {24'd0, port_q}, 32'hA5);

    // R6 sweep
    for (int c = 0; c < 128; c++) begin
      tmr8_pin_sel = c[6:3]; sub_present = c[2]; t16_sub_sel = c[1]; wt_sub_sel = c[0];
      #1;
      chk("R6 timers", {26'd0, tmr8_en, t16_en, wt_en},
          {26'd0, c[6:3], c[1] & c[2], c[0] & c[2]});
      chk("R3 sub clk", {31'd0, sub_clk_en}, {31'd0, c[2]});
    end
    // R7 sweep
    for (int c = 0; c < 16; c++) begin
      ser_ext_clk = c[3:2]; ser_i2c = c[1:0];
      #1;
      chk("R7 serial", {30'd0, ser_en}, {30'd0, c[3:2] & ~c[1:0]});
    end
    chk("R7 fixed", {29'd0, adc_en, dac_en, extint_en}, 32'd3);

    // R8: non-waking interrupts, R9 pending
    step();
    for (int b = 0; b < NOTH; b++) begin
      other_irq = 4'(1 << b); step(); other_irq = 0;
      chk("R8 no wake", {30'd0, status}, 32'd2);
      chk("R9 not forwarded", {28'd0, irq_out}, 32'd0);
    end
    step();
    ext_irq = 6'h04; step(); ext_irq = 0;
    chk("R8 wake ext", {30'd0, status}, 32'd3);
    wake_and_count(2, n);
    chk("R9 forwarded", {28'd0, irq_out}, 32'hF);
    chk("R1 run enables", {29'd0, main_clk_en, cpu_run, bus_oe}, 32'd7);
    step();
    chk("R9 cleared", {28'd0, irq_out}, 32'd0);
    chk("R4 follow after wake", {24'd0, port_q}, 32'h3C);

    // R8 each wake source, R10 sweep of settling length
    for (int s = 0; s < 8; s++) begin
      stab_cycles = 8'(s % 6);
      go_stop();
      if (s == 0) nmi = 1;
      else if (s <= 6) ext_irq = 6'(1 << (s - 1));
      else wt_irq = 1;
      step();
      nmi = 0; ext_irq = 0; wt_irq = 0;
      chk("R8 wake source", {30'd0, status}, 32'd3);
      wake_and_count(s % 6, n);
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule